// File: doc/BRIEF.md
# ASID-Scoped TLB Invalidation Engine

This block holds a small fully associative translation cache. Each entry carries a virtual page tag, an address-space identifier (ASID), a virtual-machine identifier (VMID), a security-state code, an XS attribute and a flag that marks the entry as belonging to the EL1&0 translation regime. A requester issues an invalidate-by-ASID command. The command carries a 64-bit operand, the VMID and security state of the issuing context, and a mode bit. The mode bit selects either every attribute or the variant that leaves XS entries alone.

On acceptance the engine does three things. It pulses an invalidate strobe to every peer port in the shareability domain. It marks every memory access that is in flight at that moment. It then walks the table, checking one entry per clock cycle and clearing each entry that is in scope. Once the walk ends, completion is held back until every marked in-scope access has retired. In the XS-excluding mode, only accesses with XS at 0 hold it back. While the engine is busy it refuses new commands, and lookups that land on in-scope entries report a miss.

Top module: `tlb_asid_inval`

## Requirements
- R1: After reset, `inv_ready` is 1, while `inv_busy`, `inv_done`, `peer_inval` and `lk_hit` are 0, and every entry is invalid.
- R2: The ASID of a command is taken from operand bits [63:48]. Operand bits [47:0] have no effect on which entries are cleared.
- R3: An entry is cleared only when its ASID, its VMID and its security state all equal those of the command, and its EL1&0 regime flag is 1.
- R4: The ASID comparison uses all 16 bits, so ASID 0x0034 and ASID 0x1234 are distinct.
- R5: With `inv_excl_xs`=0, matching entries are cleared whatever their XS bit. With `inv_excl_xs`=1, matching entries with XS=1 stay valid. This is the default for parameter `CLR_XS_EXCL`=0.
- R6: A command is accepted at a rising edge where `inv_valid` and `inv_ready` are both 1. After that edge `inv_busy` is 1 and `inv_ready` is 0 until completion. Commands offered while busy are ignored.
- R7: After the accepting edge, every bit of `peer_inval` is 1 for exactly one cycle.
- R8: `inv_done` is a one-cycle pulse. It occurs no earlier than ENTRIES+1 edges after the accepting edge, and `inv_busy` falls and `inv_ready` rises at the same edge.
- R9: Completion waits for in-scope accesses that were outstanding at the accepting edge. In the all-attributes mode every such access counts. In the XS-excluding mode only accesses with XS=0 count. Accesses that are issued at or after the accepting edge, or that have a different ASID, VMID or security state, never delay completion. `inv_done` rises one edge after the last blocking access retires.
- R10: The lookup result appears one edge after `lk_valid`. The hit index is the lowest matching entry. While busy, a lookup whose matching entry is in scope of the current command reports a miss.
- R11: `fill_en` writes the page tag, ASID, VMID, security state, XS bit and regime flag into entry `fill_idx` and marks it valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_valid | input | 1 | Invalidate command offered |
| inv_ready | output | 1 | Engine can take a command |
| inv_operand | input | 64 | Command operand, ASID in [63:48] |
| inv_excl_xs | input | 1 | 1 selects the XS-excluding mode |
| inv_vmid | input | VMID_W | VMID of the issuing context |
| inv_sec | input | SEC_W | Security state of the issuing context |
| inv_busy | output | 1 | Command in progress |
| inv_done | output | 1 | Completion pulse |
| peer_inval | output | PEERS | Invalidate strobe to each peer port |
| fill_en | input | 1 | Write an entry |
| fill_idx | input | log2(ENTRIES) | Entry to write |
| fill_vpn | input | VPN_W | Page tag |
| fill_asid | input | 16 | Entry ASID |
| fill_vmid | input | VMID_W | Entry VMID |
| fill_sec | input | SEC_W | Entry security state |
| fill_xs | input | 1 | Entry XS attribute |
| fill_el10 | input | 1 | Entry belongs to the EL1&0 regime |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup page tag |
| lk_asid | input | 16 | Lookup ASID |
| lk_vmid | input | VMID_W | Lookup VMID |
| lk_sec | input | SEC_W | Lookup security state |
| lk_hit | output | 1 | Lookup hit, registered |
| lk_idx | output | log2(ENTRIES) | Lowest hitting entry |
| acc_issue | input | 1 | Memory access starts |
| acc_issue_slot | input | log2(SLOTS) | Tracking slot of the new access |
| acc_asid | input | 16 | ASID of the translation used |
| acc_vmid | input | VMID_W | VMID of the translation used |
| acc_sec | input | SEC_W | Security state of the translation used |
| acc_xs | input | 1 | XS attribute of the access |
| acc_retire | input | 1 | Memory access finished |
| acc_retire_slot | input | log2(SLOTS) | Slot of the finished access |

## Verification
The lookup result is due one edge after the request. `inv_busy`, `inv_ready` and the peer strobe change one edge after acceptance. `inv_done` is due at edge ENTRIES+1 after acceptance, or one edge after the last blocking retirement if that comes later. The reference model in the bench advances at the same rising edges from the same inputs. Every output is compared with it on the following falling edge, so each result is checked in the exact cycle it is due. This includes the cycles where `inv_done` must stay low while a marked access is still outstanding.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;
  localparam int ASID_W   = 16;
  localparam int OPND_W   = 64;
  localparam int ASID_LSB = 48;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_DRAIN = 2'd2
  } inv_state_t;
endpackage

// File: rtl/tlbi_entry_array.sv
module tlbi_entry_array
  import tlbi_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int VPN_W       = 20,
  parameter int VMID_W      = 16,
  parameter int SEC_W       = 2,
  parameter bit CLR_XS_EXCL = 1'b0,
  parameter int IDX_W       = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VMID_W-1:0] fill_vmid,
  input  logic [SEC_W-1:0]  fill_sec,
  input  logic              fill_xs,
  input  logic              fill_el10,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic [SEC_W-1:0]  lk_sec,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic              busy,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [ASID_W-1:0] r_asid,
  input  logic [VMID_W-1:0] r_vmid,
  input  logic [SEC_W-1:0]  r_sec,
  input  logic              r_excl
);
  logic [ENTRIES-1:0] e_valid;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [VMID_W-1:0]  e_vmid [ENTRIES];
  logic [SEC_W-1:0]   e_sec  [ENTRIES];
  logic [ENTRIES-1:0] e_xs;
  logic [ENTRIES-1:0] e_el10;

  logic [ENTRIES-1:0] in_scope;
  logic [ENTRIES-1:0] hit_vec;

  // per-entry comparators
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign in_scope[g] = e_el10[g]
                       & (e_asid[g] == r_asid)
                       & (e_vmid[g] == r_vmid)
                       & (e_sec[g]  == r_sec)
                       & (~r_excl | ~e_xs[g] | CLR_XS_EXCL);
    assign hit_vec[g]  = e_valid[g]
                       & (e_vpn[g]  == lk_vpn)
                       & (e_asid[g] == lk_asid)
                       & (e_vmid[g] == lk_vmid)
                       & (e_sec[g]  == lk_sec)
                       & ~(busy & in_scope[g]);
  end

  // valid bits: sweep clear, then fill overrides
  always_ff @(posedge clk) begin
    if (rst) begin
      e_valid <= '0;
    end else begin
      if (clr_en && in_scope[clr_idx]) e_valid[clr_idx] <= 1'b0;
      if (fill_en)                     e_valid[fill_idx] <= 1'b1;
    end
  end

  // tag payload, no reset
  always_ff @(posedge clk) begin
    if (fill_en) begin
      e_vpn[fill_idx]  <= fill_vpn;
      e_asid[fill_idx] <= fill_asid;
      e_vmid[fill_idx] <= fill_vmid;
      e_sec[fill_idx]  <= fill_sec;
      e_xs[fill_idx]   <= fill_xs;
      e_el10[fill_idx] <= fill_el10;
    end
  end

  logic             any_hit;
  logic [IDX_W-1:0] first_hit;

  always_comb begin
    any_hit   = 1'b0;
    first_hit = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit   = 1'b1;
        first_hit = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit <= 1'b0;
      lk_idx <= '0;
    end else begin
      lk_hit <= lk_valid & any_hit;
      lk_idx <= first_hit;
    end
  end
endmodule

// File: rtl/tlbi_acc_tracker.sv
module tlbi_acc_tracker
  import tlbi_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int VMID_W = 16,
  parameter int SEC_W  = 2,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_issue,
  input  logic [SLOT_W-1:0] acc_issue_slot,
  input  logic [ASID_W-1:0] acc_asid,
  input  logic [VMID_W-1:0] acc_vmid,
  input  logic [SEC_W-1:0]  acc_sec,
  input  logic              acc_xs,
  input  logic              acc_retire,
  input  logic [SLOT_W-1:0] acc_retire_slot,
  input  logic              snap_take,
  input  logic [ASID_W-1:0] r_asid,
  input  logic [VMID_W-1:0] r_vmid,
  input  logic [SEC_W-1:0]  r_sec,
  input  logic              r_excl,
  output logic              blocked
);
  logic [SLOTS-1:0]  s_valid;
  logic [SLOTS-1:0]  s_snap;
  logic [ASID_W-1:0] s_asid [SLOTS];
  logic [VMID_W-1:0] s_vmid [SLOTS];
  logic [SEC_W-1:0]  s_sec  [SLOTS];
  logic [SLOTS-1:0]  s_xs;
  logic [SLOTS-1:0]  s_block;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign s_block[g] = s_valid[g] & s_snap[g]
                      & (s_asid[g] == r_asid)
                      & (s_vmid[g] == r_vmid)
                      & (s_sec[g]  == r_sec)
                      & (~r_excl | ~s_xs[g]);
  end

  assign blocked = |s_block;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= '0;
      s_snap  <= '0;
    end else begin
      if (snap_take) s_snap <= s_valid;
      if (acc_retire) begin
        s_valid[acc_retire_slot] <= 1'b0;
        s_snap[acc_retire_slot]  <= 1'b0;
      end
      if (acc_issue) begin
        s_valid[acc_issue_slot] <= 1'b1;
        s_snap[acc_issue_slot]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc_issue) begin
      s_asid[acc_issue_slot] <= acc_asid;
      s_vmid[acc_issue_slot] <= acc_vmid;
      s_sec[acc_issue_slot]  <= acc_sec;
      s_xs[acc_issue_slot]   <= acc_xs;
    end
  end
endmodule

// File: rtl/tlbi_ctrl.sv
module tlbi_ctrl
  import tlbi_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VMID_W  = 16,
  parameter int SEC_W   = 2,
  parameter int PEERS   = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_excl,
  input  logic [VMID_W-1:0] req_vmid,
  input  logic [SEC_W-1:0]  req_sec,
  input  logic              blocked,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic [PEERS-1:0]  bcast,
  output logic              sweep_en,
  output logic [IDX_W-1:0]  sweep_idx,
  output logic [ASID_W-1:0] r_asid,
  output logic [VMID_W-1:0] r_vmid,
  output logic [SEC_W-1:0]  r_sec,
  output logic              r_excl,
  output logic              snap_take
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  inv_state_t       state;
  logic [IDX_W-1:0] ptr;
  logic             accept;

  assign accept    = req_valid & req_ready & (state == ST_IDLE);
  assign snap_take = accept;
  assign sweep_en  = (state == ST_SWEEP);
  assign sweep_idx = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      req_ready <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
      bcast     <= '0;
      r_asid    <= '0;
      r_vmid    <= '0;
      r_sec     <= '0;
      r_excl    <= 1'b0;
    end else begin
      done  <= 1'b0;
      bcast <= '0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            r_asid    <= req_asid;
            r_vmid    <= req_vmid;
            r_sec     <= req_sec;
            r_excl    <= req_excl;
            ptr       <= '0;
            busy      <= 1'b1;
            req_ready <= 1'b0;
            bcast     <= '1;
            state     <= ST_SWEEP;
          end
        end
        ST_SWEEP: begin
          if (ptr == LAST_IDX) state <= ST_DRAIN;
          else                 ptr   <= ptr + 1'b1;
        end
        ST_DRAIN: begin
          if (!blocked) begin
            done      <= 1'b1;
            busy      <= 1'b0;
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlb_asid_inval.sv
module tlb_asid_inval
  import tlbi_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int VPN_W       = 20,
  parameter int VMID_W      = 16,
  parameter int SEC_W       = 2,
  parameter int SLOTS       = 8,
  parameter int PEERS       = 4,
  parameter bit CLR_XS_EXCL = 1'b0,
  parameter int IDX_W       = $clog2(ENTRIES),
  parameter int SLOT_W      = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_valid,
  output logic              inv_ready,
  input  logic [OPND_W-1:0] inv_operand,
  input  logic              inv_excl_xs,
  input  logic [VMID_W-1:0] inv_vmid,
  input  logic [SEC_W-1:0]  inv_sec,
  output logic              inv_busy,
  output logic              inv_done,
  output logic [PEERS-1:0]  peer_inval,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VMID_W-1:0] fill_vmid,
  input  logic [SEC_W-1:0]  fill_sec,
  input  logic              fill_xs,
  input  logic              fill_el10,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic [SEC_W-1:0]  lk_sec,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic              acc_issue,
  input  logic [SLOT_W-1:0] acc_issue_slot,
  input  logic [ASID_W-1:0] acc_asid,
  input  logic [VMID_W-1:0] acc_vmid,
  input  logic [SEC_W-1:0]  acc_sec,
  input  logic              acc_xs,
  input  logic              acc_retire,
  input  logic [SLOT_W-1:0] acc_retire_slot
);
  logic [ASID_W-1:0] cmd_asid;
  logic              unused_rsvd;

  // ASID field of the operand; the low part is reserved
  assign cmd_asid    = inv_operand[ASID_LSB +: ASID_W];
  assign unused_rsvd = ^inv_operand[ASID_LSB-1:0];

  logic              sweep_en;
  logic [IDX_W-1:0]  sweep_idx;
  logic [ASID_W-1:0] r_asid;
  logic [VMID_W-1:0] r_vmid;
  logic [SEC_W-1:0]  r_sec;
  logic              r_excl;
  logic              snap_take;
  logic              blocked;

  tlbi_ctrl #(
    .ENTRIES(ENTRIES), .VMID_W(VMID_W), .SEC_W(SEC_W), .PEERS(PEERS)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(inv_valid), .req_asid(cmd_asid), .req_excl(inv_excl_xs),
    .req_vmid(inv_vmid), .req_sec(inv_sec), .blocked(blocked),
    .req_ready(inv_ready), .busy(inv_busy), .done(inv_done), .bcast(peer_inval),
    .sweep_en(sweep_en), .sweep_idx(sweep_idx),
    .r_asid(r_asid), .r_vmid(r_vmid), .r_sec(r_sec), .r_excl(r_excl),
    .snap_take(snap_take)
  );

  tlbi_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .VMID_W(VMID_W), .SEC_W(SEC_W),
    .CLR_XS_EXCL(CLR_XS_EXCL)
  ) u_array (
    .clk(clk), .rst(rst),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_vmid(fill_vmid), .fill_sec(fill_sec),
    .fill_xs(fill_xs), .fill_el10(fill_el10),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_vmid(lk_vmid), .lk_sec(lk_sec), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .busy(inv_busy), .clr_en(sweep_en), .clr_idx(sweep_idx),
    .r_asid(r_asid), .r_vmid(r_vmid), .r_sec(r_sec), .r_excl(r_excl)
  );

  tlbi_acc_tracker #(
    .SLOTS(SLOTS), .VMID_W(VMID_W), .SEC_W(SEC_W)
  ) u_track (
    .clk(clk), .rst(rst),
    .acc_issue(acc_issue), .acc_issue_slot(acc_issue_slot),
    .acc_asid(acc_asid), .acc_vmid(acc_vmid), .acc_sec(acc_sec),
    .acc_xs(acc_xs), .acc_retire(acc_retire), .acc_retire_slot(acc_retire_slot),
    .snap_take(snap_take),
    .r_asid(r_asid), .r_vmid(r_vmid), .r_sec(r_sec), .r_excl(r_excl),
    .blocked(blocked)
  );
endmodule

// File: rtl/tlbi_checker.sv
module tlbi_checker #(
  parameter int ENTRIES = 16,
  parameter int PEERS   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             inv_ready,
  input logic             inv_busy,
  input logic             inv_done,
  input logic [PEERS-1:0] peer_inval,
  input logic             lk_valid,
  input logic             lk_hit
);
  logic [31:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= '0;
    else     busy_cnt <= inv_busy ? busy_cnt + 1'b1 : '0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (inv_ready && !inv_busy && !inv_done && peer_inval == '0));

  // R6
  ready_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    inv_busy |-> !inv_ready);

  // R7
  bcast_all_peers_chk: assert property (@(posedge clk) disable iff (rst)
    (peer_inval != '0) |-> (peer_inval == {PEERS{1'b1}}) && inv_busy);

  // R7
  bcast_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (peer_inval != '0) |=> (peer_inval == '0));

  // R8
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    inv_done |-> (!inv_busy && inv_ready && $past(inv_busy)));

  // R8
  done_min_latency_chk: assert property (@(posedge clk) disable iff (rst)
    inv_done |-> (busy_cnt >= 32'(ENTRIES + 1)));

  // R8
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    inv_done |=> !inv_done);

  // R10
  hit_needs_lookup_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(lk_valid));
endmodule

bind tlb_asid_inval tlbi_checker #(
  .ENTRIES(ENTRIES), .PEERS(PEERS)
) u_chk (
  .clk(clk), .rst(rst), .inv_ready(inv_ready), .inv_busy(inv_busy),
  .inv_done(inv_done), .peer_inval(peer_inval),
  .lk_valid(lk_valid), .lk_hit(lk_hit)
);

// File: tb/tlb_asid_inval_bench.sv
module tlb_asid_inval_bench;
  localparam int E  = 16;
  localparam int S  = 8;
  localparam int P  = 4;
  localparam int VW = 20;
  localparam int MW = 16;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic          inv_valid = 0, inv_excl_xs = 0;
  logic [63:0]   inv_operand = '0;
  logic [MW-1:0] inv_vmid = '0;
  logic [SW-1:0] inv_sec = '0;
  logic          inv_ready, inv_busy, inv_done;
  logic [P-1:0]  peer_inval;
  logic          fill_en = 0, fill_xs = 0, fill_el10 = 0;
  logic [3:0]    fill_idx = '0;
  logic [VW-1:0] fill_vpn = '0;
  logic [15:0]   fill_asid = '0;
  logic [MW-1:0] fill_vmid = '0;
  logic [SW-1:0] fill_sec = '0;
  logic          lk_valid = 0;
  logic [VW-1:0] lk_vpn = '0;
  logic [15:0]   lk_asid = '0;
  logic [MW-1:0] lk_vmid = '0;
  logic [SW-1:0] lk_sec = '0;
  logic          lk_hit;
  logic [3:0]    lk_idx;
  logic          acc_issue = 0, acc_xs = 0, acc_retire = 0;
  logic [2:0]    acc_issue_slot = '0, acc_retire_slot = '0;
  logic [15:0]   acc_asid = '0;
  logic [MW-1:0] acc_vmid = '0;
  logic [SW-1:0] acc_sec = '0;

  tlb_asid_inval u_tlb_asid_inval (
    .clk(clk), .rst(rst),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_operand(inv_operand),
    .inv_excl_xs(inv_excl_xs), .inv_vmid(inv_vmid), .inv_sec(inv_sec),
    .inv_busy(inv_busy), .inv_done(inv_done), .peer_inval(peer_inval),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_vmid(fill_vmid), .fill_sec(fill_sec),
    .fill_xs(fill_xs), .fill_el10(fill_el10),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_vmid(lk_vmid), .lk_sec(lk_sec), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .acc_issue(acc_issue), .acc_issue_slot(acc_issue_slot),
    .acc_asid(acc_asid), .acc_vmid(acc_vmid), .acc_sec(acc_sec),
    .acc_xs(acc_xs), .acc_retire(acc_retire), .acc_retire_slot(acc_retire_slot)
  );

  // ---------------- reference model ----------------
  bit          m_v [E];
  int          m_vpn [E], m_asid [E], m_vmid [E], m_sec [E];
  bit          m_xs [E], m_el [E];
  bit          s_v [S], s_snap [S], s_xs [S];
  int          s_asid [S], s_vmid [S], s_sec [S];
  int          q_asid, q_vmid, q_sec;
  bit          q_excl;
  int          m_phase, m_ptr;
  bit          m_ready, m_busy, m_done, m_bcast, m_lhit;
  int          m_lidx;

  function automatic bit in_scope(int i);
    return m_el[i] && m_asid[i] == q_asid && m_vmid[i] == q_vmid &&
           m_sec[i] == q_sec && (!q_excl || !m_xs[i]);
  endfunction

  always @(posedge clk) begin
    bit nh, blk;
    int ni;
    if (rst) begin
      for (int i = 0; i < E; i++) m_v[i] = 0;
      for (int j = 0; j < S; j++) begin s_v[j] = 0; s_snap[j] = 0; end
      m_phase = 0; m_ptr = 0; m_ready = 1; m_busy = 0; m_done = 0;
      m_bcast = 0; m_lhit = 0; m_lidx = 0;
      q_asid = 0; q_vmid = 0; q_sec = 0; q_excl = 0;
    end else begin
      nh = 0; ni = 0;
      if (lk_valid)
        for (int i = E - 1; i >= 0; i--)
          if (m_v[i] && m_vpn[i] == int'(lk_vpn) && m_asid[i] == int'(lk_asid) &&
              m_vmid[i] == int'(lk_vmid) && m_sec[i] == int'(lk_sec) &&
              !(m_busy && in_scope(i))) begin
            nh = 1; ni = i;
          end
      blk = 0;
      for (int j = 0; j < S; j++)
        if (s_v[j] && s_snap[j] && s_asid[j] == q_asid && s_vmid[j] == q_vmid &&
            s_sec[j] == q_sec && (!q_excl || !s_xs[j])) blk = 1;
      m_done = 0; m_bcast = 0;
      case (m_phase)
        0: if (inv_valid && m_ready) begin
             q_asid = int'(inv_operand[63:48]); q_vmid = int'(inv_vmid);
             q_sec = int'(inv_sec); q_excl = inv_excl_xs;
             m_phase = 1; m_ptr = 0; m_busy = 1; m_ready = 0; m_bcast = 1;
             for (int j = 0; j < S; j++) s_snap[j] = s_v[j];
           end
        1: begin
             if (in_scope(m_ptr)) m_v[m_ptr] = 0;
             if (m_ptr == E - 1) m_phase = 2; else m_ptr++;
           end
        default: if (!blk) begin
             m_done = 1; m_busy = 0; m_ready = 1; m_phase = 0;
           end
      endcase
      if (fill_en) begin
        m_v[fill_idx] = 1; m_vpn[fill_idx] = int'(fill_vpn);
        m_asid[fill_idx] = int'(fill_asid); m_vmid[fill_idx] = int'(fill_vmid);
        m_sec[fill_idx] = int'(fill_sec); m_xs[fill_idx] = fill_xs;
        m_el[fill_idx] = fill_el10;
      end
      if (acc_retire) begin s_v[acc_retire_slot] = 0; s_snap[acc_retire_slot] = 0; end
      if (acc_issue) begin
        s_v[acc_issue_slot] = 1; s_snap[acc_issue_slot] = 0;
        s_asid[acc_issue_slot] = int'(acc_asid); s_vmid[acc_issue_slot] = int'(acc_vmid);
        s_sec[acc_issue_slot] = int'(acc_sec); s_xs[acc_issue_slot] = acc_xs;
      end
      m_lhit = nh; m_lidx = ni;
    end
  end

  // ---------------- checking ----------------
  int    n_cmp = 0, n_bad = 0, cycles = 0;
  string cur = "R1";
  bit    finished = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(inv_ready == m_ready, "R6", "inv_ready", int'(inv_ready), int'(m_ready));
      chk(inv_busy == m_busy, "R6", "inv_busy", int'(inv_busy), int'(m_busy));
      chk(peer_inval == (m_bcast ? 4'hF : 4'h0), "R7", "peer_inval",
          int'(peer_inval), m_bcast ? 15 : 0);
      chk(inv_done == m_done, cur, "inv_done", int'(inv_done), int'(m_done));
      chk(lk_hit == m_lhit, cur, "lk_hit", int'(lk_hit), int'(m_lhit));
      if (m_lhit) chk(int'(lk_idx) == m_lidx, cur, "lk_idx", int'(lk_idx), m_lidx);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000 && !finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic fill(int idx, int asid, int vmid, int sec, bit xs, bit el);
    fill_en = 1; fill_idx = 4'(idx); fill_vpn = VW'(32'h100 + idx);
    fill_asid = 16'(asid); fill_vmid = MW'(vmid); fill_sec = SW'(sec);
    fill_xs = xs; fill_el10 = el;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic look(int idx, int asid, int vmid, int sec);
    lk_valid = 1; lk_vpn = VW'(32'h100 + idx); lk_asid = 16'(asid);
    lk_vmid = MW'(vmid); lk_sec = SW'(sec);
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic req(int asid, logic [47:0] low, bit excl, int vmid, int sec);
    inv_valid = 1; inv_operand = {16'(asid), low}; inv_excl_xs = excl;
    inv_vmid = MW'(vmid); inv_sec = SW'(sec);
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic issue(int slot, int asid, int vmid, int sec, bit xs);
    acc_issue = 1; acc_issue_slot = 3'(slot); acc_asid = 16'(asid);
    acc_vmid = MW'(vmid); acc_sec = SW'(sec); acc_xs = xs;
    @(negedge clk);
    acc_issue = 0;
  endtask

  task automatic retire(int slot);
    acc_retire = 1; acc_retire_slot = 3'(slot);
    @(negedge clk);
    acc_retire = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!m_done && n < 400) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk(inv_ready == 1'b1, "R1", "reset inv_ready", int'(inv_ready), 1);
    chk(inv_busy == 1'b0, "R1", "reset inv_busy", int'(inv_busy), 0);
    chk(inv_done == 1'b0, "R1", "reset inv_done", int'(inv_done), 0);
    chk(peer_inval == 4'h0, "R1", "reset peer_inval", int'(peer_inval), 0);
    chk(lk_hit == 1'b0, "R1", "reset lk_hit", int'(lk_hit), 0);
    rst = 0;
    cur = "R1"; look(0, 0, 0, 0);           // empty table misses

    cur = "R11";
    fill(0, 'h1234, 5, 1, 0, 1);
    fill(1, 'h1234, 5, 1, 1, 1);
    fill(2, 'h1234, 6, 1, 0, 1);
    fill(3, 'h1234, 5, 0, 0, 1);
    fill(4, 'h1234, 5, 1, 0, 0);
    fill(5, 'h0034, 5, 1, 0, 1);
    fill(6, 'h1234, 5, 1, 0, 1);
    look(0, 'h1234, 5, 1); look(1, 'h1234, 5, 1); look(6, 'h1234, 5, 1);
    look(6, 'h1234, 5, 2);                   // wrong security state misses

    // R2: reserved operand bits full of ones; XS-excluding mode
    cur = "R2";
    req('h1234, 48'hFFFF_FFFF_FFFF, 1, 5, 1);
    cur = "R10";
    look(6, 'h1234, 5, 1);                   // in scope while busy: miss
    look(2, 'h1234, 6, 1);                   // out of scope: hit
    cur = "R6";
    req('h0034, 48'h0, 0, 5, 1);             // offered while busy
    wait_done();
    cur = "R3"; look(0, 'h1234, 5, 1); look(6, 'h1234, 5, 1);
    look(2, 'h1234, 6, 1); look(3, 'h1234, 5, 0); look(4, 'h1234, 5, 1);
    cur = "R4"; look(5, 'h0034, 5, 1);
    cur = "R5"; look(1, 'h1234, 5, 1);       // XS=1 kept in excluding mode

    // R5: all-attributes mode clears the XS=1 entry
    req('h1234, 48'h0, 0, 5, 1);
    wait_done();
    look(1, 'h1234, 5, 1);

    // R9: drain in excluding mode
    cur = "R9";
    issue(0, 'h0034, 5, 1, 0);
    issue(1, 'h0034, 5, 1, 1);
    issue(2, 'h0777, 5, 1, 0);
    req('h0034, 48'h0, 1, 5, 1);
    issue(3, 'h0034, 5, 1, 0);               // issued after acceptance
    repeat (30) @(negedge clk);
    retire(0);
    wait_done();
    cur = "R4"; look(5, 'h0034, 5, 1);

    // R9: drain in all-attributes mode, XS=1 access now blocks
    cur = "R9";
    fill(5, 'h0034, 5, 1, 0, 1);
    req('h0034, 48'h0, 0, 5, 1);
    repeat (25) @(negedge clk);
    retire(1);
    wait_done();
    retire(3); retire(2);

    // R8: no blocking access, completion right after the sweep
    cur = "R8";
    req('h0777, 48'h0, 0, 5, 1);
    wait_done();
    repeat (3) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule